// File: doc/BRIEF.md
# Saturating CPU-Cycle Interrupt Timer

This block is a 15-bit up-counter that advances once per qualified CPU cycle and raises an interrupt when it climbs to its all-ones value, where it then parks. There is no reload register. Software sees the live count through two byte-wide windows. The low window holds the bottom eight bits. The high window holds the top seven bits together with an enable flag in its most significant bit.

A strobed access is any access made with `cpu_cycle_i` high. Any strobed read or write of either window acknowledges a pending interrupt. Writes replace the count bits directly and take precedence over that cycle's increment. The interrupt output is active low and is driven only while the enable flag and the pending flag are both set.

Software typically writes a start value with the enable bit set, then waits for the line to fall. It acknowledges the interrupt by touching either window.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset (`rst_ni` low) the count is 0, the enable flag is 0 and the pending flag is 0. `irq_no` is 1, and both windows read 0x00.
- R2: The low window is selected when `addr_i[15:11]` = 5'b01010. A strobed write with `rnw_i`=0 loads count[7:0] from `wdata_i`, and a read returns count[7:0].
- R3: The high window is selected when `addr_i[15:11]` = 5'b01011. A strobed write loads count[14:8] from `wdata_i[6:0]` and the enable flag from `wdata_i[7]`. A read returns {enable, count[14:8]}.
- R4: While enable is 1, each cycle with `cpu_cycle_i` high and no window write adds exactly 1 to the count. When enable is 0 or `cpu_cycle_i` is 0, the count holds.
- R5: Once the count is 0x7FFF it stays at 0x7FFF until a write changes it.
- R6: The pending flag is set only by the increment that takes the count from 0x7FFE to 0x7FFF. A write that loads 0x7FFF does not set it. `irq_no` is 0 exactly while enable and pending are both 1.
- R7: Any strobed read or write of either window clears the pending flag. If a strobed read coincides with the increment that reaches 0x7FFF, the set wins and the flag ends at 1.
- R8: A strobed window write suppresses that cycle's increment. Bits that are not written keep their value.
- R9: Accesses outside both windows, and accesses with `cpu_cycle_i` low, change neither the count, the enable flag nor the pending flag. Reads outside the windows return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_cycle_i | input | 1 | Qualifies one CPU cycle: counting and bus access happen only when high |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rnw_i | input | 1 | 1 = read, 0 = write |
| rdata_o | output | 8 | Read data of the selected window, 0 otherwise |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a window write and the increment. The bench provokes it by writing while counting is enabled, including a write made at 0x7FFE that would otherwise have reached the maximum. It judges the case by the exact count read back and by an interrupt line that stays high.

The second pair is an acknowledging read and the increment that reaches 0x7FFF. The bench issues the read on exactly that cycle and expects the interrupt line to fall, because the set must win. A behavioural model compares the read data and the interrupt line on every clock.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned WIN_W  = 5;
  localparam logic [WIN_W-1:0] LO_TAG = 5'b01010;
  localparam logic [WIN_W-1:0] HI_TAG = 5'b01011;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LO   = 2'd1,
    WIN_HI   = 2'd2
  } win_e;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
(
  input  logic              cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  output win_e              win_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              ack_o
);
  logic [WIN_W-1:0] tag;
  assign tag = addr_i[ADDR_W-1 -: WIN_W];

  always_comb begin
    unique case (tag)
      LO_TAG:  win_o = WIN_LO;
      HI_TAG:  win_o = WIN_HI;
      default: win_o = WIN_NONE;
    endcase
  end

  assign ack_o   = cyc_i && (win_o != WIN_NONE);
  assign wr_lo_o = cyc_i && !rnw_i && (win_o == WIN_LO);
  assign wr_hi_o = cyc_i && !rnw_i && (win_o == WIN_HI);
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2*DATA_W - 1,
  localparam int unsigned HI_W  = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - ONE;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             adv;

  // writes win over the increment; counting parks at the maximum
  assign adv   = cyc_i && en_q && !wr_lo_i && !wr_hi_i && (cnt_q != CNT_MAX);
  assign hit_o = adv && (cnt_q == CNT_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      if (wr_lo_i) cnt_q[DATA_W-1:0] <= wdata_i;
      if (wr_hi_i) begin
        cnt_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        en_q                  <= wdata_i[DATA_W-1];
      end
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && en_q && !wr_lo_i && !wr_hi_i && cnt_q != CNT_MAX)
      |=> cnt_q == $past(cnt_q) + ONE);

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> $stable(cnt_q) && $stable(en_q));

  a_r5_park_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !wr_lo_i && !wr_hi_i) |=> cnt_q == CNT_MAX);

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_q[DATA_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  input  logic en_i,
  output logic irq_no
);
  logic pend_q;

  // set beats acknowledge when both fall in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (hit_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign irq_no = !(pend_q && en_i);

  a_r6_set_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pend_q);

  a_r6_only_from_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(hit_i));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit_i) |=> !pend_q);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_cycle_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rnw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  localparam int unsigned CNT_W = 2*DATA_W - 1;

  win_e             win;
  logic             wr_lo, wr_hi, ack;
  logic [CNT_W-1:0] cnt;
  logic             en, hit;

  cyc_irq_decode u_decode (
    .cyc_i   (cpu_cycle_i),
    .addr_i  (addr_i),
    .rnw_i   (rnw_i),
    .win_o   (win),
    .wr_lo_o (wr_lo),
    .wr_hi_o (wr_hi),
    .ack_o   (ack)
  );

  cyc_irq_counter #(.DATA_W(DATA_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cyc_i   (cpu_cycle_i),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .en_o    (en),
    .hit_o   (hit)
  );

  cyc_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .ack_i  (ack),
    .en_i   (en),
    .irq_no (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    if (rnw_i) begin
      unique case (win)
        WIN_LO:  rdata_o = cnt[DATA_W-1:0];
        WIN_HI:  rdata_o = {en, cnt[CNT_W-1:DATA_W]};
        default: rdata_o = '0;
      endcase
    end
  end

  a_r9_quiet_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnw_i && win == WIN_NONE) |-> rdata_o == '0);
endmodule

// File: tb/cyc_irq_timer_test.sv
module cyc_irq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        rnw = 1'b1;
  logic [7:0]  rdata;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0;
  int m_en = 0;
  int m_pend = 0;

  always #4 clk = ~clk;  // 125 MHz

  cyc_irq_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_cycle_i(cyc), .addr_i(addr),
    .wdata_i(wdata), .rnw_i(rnw), .rdata_o(rdata), .irq_no(irq_n)
  );

  function automatic int win_of(input logic [15:0] a);
    if (a[15:11] == 5'b01010) return 1;
    if (a[15:11] == 5'b01011) return 2;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_pend = 0;
    end else if (cyc) begin
      int w;
      bit hit;
      w = win_of(addr);
      hit = 0;
      if (!rnw && w == 1) m_cnt = (m_cnt & 32'h7F00) | int'(wdata);
      else if (!rnw && w == 2) begin
        m_cnt = (m_cnt & 32'hFF) | (int'(wdata & 8'h7F) << 8);
        m_en = int'(wdata[7]);
      end else if (m_en == 1 && m_cnt != 32'h7FFF) begin
        m_cnt++;
        if (m_cnt == 32'h7FFF) hit = 1;
      end
      if (hit) m_pend = 1;
      else if (w != 0) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int w, er;
      w = win_of(addr);
      er = 0;
      if (rnw && w == 1) er = m_cnt & 32'hFF;
      if (rnw && w == 2) er = (m_en << 7) | (m_cnt >> 8);
      chk("R2 R3 R9 model rdata", int'(rdata), er);
      chk("R6 model irq_no", int'(irq_n), (m_en == 1 && m_pend == 1) ? 0 : 1);
    end
  end

  task automatic op(input logic [15:0] a, input logic r, input logic [7:0] d, input logic s);
    addr = a; rnw = r; wdata = d; cyc = s;
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(16'h0000, 1'b1, 8'h00, 1'b1);
  endtask

  task automatic peek(input logic [15:0] a, input int exp, input string tag);
    addr = a; rnw = 1'b1; cyc = 1'b0; #1;
    chk(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    peek(16'h5000, 8'h00, "R1 low after reset");
    peek(16'h5800, 8'h00, "R1 high after reset");
    chk("R1 irq_no after reset", int'(irq_n), 1);

    op(16'h5000, 1'b0, 8'h34, 1'b1);
    op(16'h5800, 1'b0, 8'h12, 1'b1);
    peek(16'h5000, 8'h34, "R2 low readback");
    peek(16'h57FF, 8'h34, "R2 low window top");
    peek(16'h5800, 8'h12, "R3 high readback");
    idle(5);
    peek(16'h5000, 8'h34, "R4 hold when disabled");

    op(16'h5800, 1'b0, 8'h92, 1'b1);
    idle(16);
    peek(16'h5000, 8'h44, "R4 sixteen steps");
    peek(16'h5800, 8'h92, "R3 enable bit readback");
    for (int i = 0; i < 4; i++) op(16'h0000, 1'b1, 8'h00, 1'b0);
    peek(16'h5000, 8'h44, "R4 hold without strobe");

    op(16'h5000, 1'b0, 8'h80, 1'b1);
    peek(16'h5000, 8'h80, "R8 write suppresses increment");
    peek(16'h5800, 8'h92, "R8 high byte kept");

    op(16'h5FFF, 1'b0, 8'hFF, 1'b1);
    idle(126);
    peek(16'h5000, 8'hFE, "R4 reach 0x7FFE");
    chk("R6 no irq before max", int'(irq_n), 1);
    idle(1);
    chk("R6 irq at max", int'(irq_n), 0);
    idle(10);
    peek(16'h5000, 8'hFF, "R5 low parked");
    peek(16'h5800, 8'hFF, "R5 high parked");
    chk("R6 irq held", int'(irq_n), 0);

    op(16'h57FF, 1'b1, 8'h00, 1'b1);
    chk("R7 read ack", int'(irq_n), 1);
    idle(5);
    chk("R6 no re-raise while parked", int'(irq_n), 1);

    op(16'h5000, 1'b0, 8'hFF, 1'b1);
    idle(3);
    chk("R6 direct write of max raises nothing", int'(irq_n), 1);

    op(16'h5000, 1'b0, 8'hFD, 1'b1);
    idle(1);
    op(16'h5000, 1'b1, 8'h00, 1'b1);
    chk("R7 set wins over same-cycle read ack", int'(irq_n), 0);
    op(16'h5800, 1'b1, 8'h00, 1'b1);
    chk("R7 high read ack", int'(irq_n), 1);

    op(16'h5000, 1'b0, 8'hFE, 1'b1);
    op(16'h5800, 1'b0, 8'hFF, 1'b1);
    chk("R8 write at 0x7FFE blocks reaching max", int'(irq_n), 1);
    peek(16'h5000, 8'hFE, "R8 count held at 0x7FFE");
    idle(1);
    chk("R6 raise after next step", int'(irq_n), 0);
    op(16'h5800, 1'b0, 8'h05, 1'b1);
    chk("R7 write ack", int'(irq_n), 1);
    idle(3);
    peek(16'h5000, 8'hFF, "R4 disabled hold");
    peek(16'h5800, 8'h05, "R3 disabled high");

    op(16'h6000, 1'b0, 8'h00, 1'b1);
    op(16'h4800, 1'b0, 8'h00, 1'b1);
    op(16'h5000, 1'b0, 8'h11, 1'b0);
    peek(16'h5000, 8'hFF, "R9 outside and unstrobed writes ignored");
    peek(16'h4FFF, 8'h00, "R9 outside read zero");

    op(16'h5000, 1'b0, 8'hFD, 1'b1);
    op(16'h5800, 1'b0, 8'hFF, 1'b1);
    idle(2);
    chk("R6 raise again", int'(irq_n), 0);
    op(16'h6000, 1'b1, 8'h00, 1'b1);
    chk("R9 outside read no ack", int'(irq_n), 0);
    op(16'h5800, 1'b1, 8'h00, 1'b0);
    chk("R9 unstrobed read no ack", int'(irq_n), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule